// File: doc/BRIEF.md
# Two-Channel Timer with Buffered PWM

The block is a 16-bit up-counter that runs from 0 to a programmable modulo value and then starts again at 0. Two capture/compare channels are attached to it. A channel in capture mode latches the counter value when its input pin shows the selected edge. A channel in compare mode drives its output pin on a counter match. It can also toggle that pin on every counter wrap. This gives edge-aligned PWM, and two extra control bits produce exact 0% and 100% duty.

Channel 0 carries a pairing bit that joins both channels into one buffered PWM generator. The comparator then uses a private live duty register. One channel's value register is the active one and the other is the idle one. Software writes the new duty into the idle register. That value becomes live at the next counter wrap, and the two channels then trade roles, so a period in progress is never cut short.

Software reaches the block over a simple register bus with address, write data, read data, a write strobe and a read strobe. A low-power hold input stops all register access while the counter keeps running. One level-sensitive interrupt output merges the counter-wrap flag and the two channel flags, each gated by its own enable bit.

Top module: `tmr2ch_pwm`

## Requirements
- R1: Out of reset the counter is stopped at 0, the modulo register (address 1) reads 0xFFFF, the timer control register (address 0) reads 0x0004, and `irq_o` and both `ch_out_o` pins are 0. When running, the counter (readable at address 2) rises by one per clock, and on the cycle after it equals the modulo value it becomes 0.
- R2: In the timer control register, bit 2 is the stop bit, which freezes the counter. Bit 3 is a write-only clear bit, which reads 0 and forces the counter to 0 at the write.
- R3: Each channel has a control register (channel 0 at address 3, channel 1 at address 5) and a value register (address 4 for channel 0, address 6 for channel 1). In a control register, bits 3:2 = 2 select compare mode and bit 8 is the pin level driven on a match. With bit 8 = 0 and the toggle bit set, the pin is high for (compare value + 1) of every (modulo + 1) cycles.
- R4: Bit 6 is toggle-on-wrap. When it is clear, a wrap leaves the pin alone, so with bit 8 = 0 the duty is 0%. When bit 7 (max duty) and bit 6 are both set, the pin is held high, which is 100% duty.
- R5: Bit 9 of channel 0's control register pairs the channels. While they are paired, channel 0's settings drive `ch_out_o[0]`, `ch_out_o[1]` stays 0, and channel 0's value register supplies the first live duty.
- R6: In paired mode, a write to the idle channel's value register becomes the live compare value at the next counter wrap, and the active and idle roles then swap. A write to the active channel's value register alone never changes the output duty.
- R7: The wrap flag (timer control bit 0) is set when the counter wraps. `irq_o` is high when any flag is set whose enable is set: the wrap enable is timer control bit 1, and each channel's enable is bit 1 of its control register.
- R8: A flag (bit 0 of its control register) is set by its event. It clears only when a read of that register sees it set and the next write to the register carries 0 in bit 0. Writing 0 with no such read, or writing 1, leaves it unchanged. An event in the same cycle as the clearing write keeps the flag set.
- R9: Bits 3:2 = 1 select capture mode. Bits 5:4 select the edge: 1 = rising, 2 = falling, 3 = both. The pin passes through two synchronizer stages, and on the chosen edge the counter value is stored in the value register and the channel flag is set. Edges that were not selected have no effect.
- R10: While `lp_hold_i` is 1, register writes and flag-arming reads are ignored and `rdata_o` reads 0. The counter and the interrupt logic keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_hold_i | input | 1 | Low-power hold: blocks register access |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (arms flag clearing) |
| rdata_o | output | 16 | Read data, combinational from address |
| ch_in_i | input | 2 | Channel capture pins |
| ch_out_o | output | 2 | Channel compare/PWM pins |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong counter or modulo state shows up within one period as a wrong high count on a compare pin, and also in the value read from address 2. A wrong active/idle role or live register in paired mode changes the measured duty within one or two periods after a wrap, and the bench measures duty over whole periods so the phase does not matter. A flag whose arm state or priority is wrong shows in the next read of bit 0 and on `irq_o` at once. A broken synchronizer or edge selector is visible five cycles after a pin change, as a wrong captured value or flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW  = 4;
  localparam int NCH = 2;

  typedef enum logic [3:0] {
    A_CTL   = 4'd0,
    A_MOD   = 4'd1,
    A_CNT   = 4'd2,
    A_C0CTL = 4'd3,
    A_C0VAL = 4'd4,
    A_C1CTL = 4'd5,
    A_C1VAL = 4'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    CM_IDLE = 2'd0,
    CM_CAP  = 2'd1,
    CM_CMP  = 2'd2,
    CM_RSV  = 2'd3
  } ch_mode_e;

  // Channel control bits 9:1; bit 0 is the flag, kept outside.
  typedef struct packed {
    logic     pair;
    logic     lvl;
    logic     max;
    logic     tov;
    logic [1:0] edge_sel;
    ch_mode_e mode;
    logic     ie;
  } ch_cfg_t;
endpackage

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_hit_i,
  input  logic wr_hit_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d, arm_q, arm_d;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (rd_hit_i && flag_q) arm_d = 1'b1;
    if (wr_hit_i) begin
      if (!wbit_i && arm_q) flag_d = 1'b0;
      arm_d = 1'b0;
    end
    if (set_i) flag_d = 1'b1;
    if (!flag_d) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_hit_i) |=> flag_q);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign wrap_o = run_i && !clr_i && (cnt_q == mod_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (run_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && cnt_q == mod_i) |=> (cnt_q == '0));
  // R2
  cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W     = 16,
  parameter int SYNCN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr_i,
  input  logic         val_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         run_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cmp_val_i,
  input  logic         cmp_en_i,
  input  logic         pin_i,
  output ch_cfg_t      cfg_o,
  output logic [W-1:0] val_o,
  output logic         pin_o,
  output logic         evt_o
);
  ch_cfg_t        cfg_q, cfg_d;
  logic [W-1:0]   val_q, val_d;
  logic [SYNCN-1:0] sync_q;
  logic           prev_q, pin_q, pin_d;
  logic           rise, fall, cap_hit, cmp_hit, is_cmp;

  assign rise    = sync_q[SYNCN-1] & ~prev_q;
  assign fall    = ~sync_q[SYNCN-1] & prev_q;
  assign cap_hit = (cfg_q.mode == CM_CAP) &&
                   ((cfg_q.edge_sel[0] && rise) || (cfg_q.edge_sel[1] && fall));
  assign is_cmp  = (cfg_q.mode == CM_CMP);
  assign cmp_hit = run_i && cmp_en_i && is_cmp && (cnt_i == cmp_val_i);

  always_comb begin
    cfg_d = cfg_q;
    val_d = val_q;
    pin_d = pin_q;
    if (cfg_wr_i) cfg_d = ch_cfg_t'(wdata_i[9:1]);
    if (cap_hit)       val_d = cnt_i;
    else if (val_wr_i) val_d = wdata_i;
    if (is_cmp && wrap_i && cfg_q.tov) pin_d = ~pin_q;
    if (cmp_hit) pin_d = cfg_q.lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      val_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      val_q  <= val_d;
      sync_q <= {sync_q[SYNCN-2:0], pin_i};
      prev_q <= sync_q[SYNCN-1];
      pin_q  <= pin_d;
    end
  end

  assign cfg_o = cfg_q;
  assign val_o = val_q;
  assign evt_o = cap_hit | cmp_hit;
  assign pin_o = is_cmp ? ((cfg_q.max && cfg_q.tov) ? 1'b1 : pin_q) : 1'b0;

  // R9
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (val_q == $past(cnt_i)));
  // R4
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmp && !cfg_q.tov && !cfg_q.lvl && !pin_q && !cfg_wr_i) |=> !pin_q);
endmodule

// File: rtl/tmr2ch_pwm.sv
module tmr2ch_pwm
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_hold_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic [W-1:0]  rdata_o,
  input  logic [NCH-1:0] ch_in_i,
  output logic [NCH-1:0] ch_out_o,
  output logic          irq_o
);
  logic [1:0]   rs_q;
  logic         rst_s_n;
  logic         wr_ok, rd_ok, ctl_wr, cnt_clr;
  logic         stop_q, stop_d, ovf_ie_q, ovf_ie_d, ovf_flag;
  logic [W-1:0] mod_q, mod_d, cnt, live_q, live_d;
  logic         wrap, paired, act_q, act_d, pend_q, pend_d;
  ch_cfg_t      ch_cfg  [NCH];
  logic [W-1:0] ch_val  [NCH];
  logic [NCH-1:0] ch_evt, ch_flag, ch_pin, ch_ie;

  // Reset: asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  assign wr_ok   = wr_en_i && !lp_hold_i;
  assign rd_ok   = rd_en_i && !lp_hold_i;
  assign ctl_wr  = wr_ok && (addr_i == A_CTL);
  assign cnt_clr = ctl_wr && wdata_i[3];
  assign paired  = ch_cfg[0].pair;

  always_comb begin
    stop_d   = stop_q;
    ovf_ie_d = ovf_ie_q;
    mod_d    = mod_q;
    if (ctl_wr) begin
      ovf_ie_d = wdata_i[1];
      stop_d   = wdata_i[2];
    end
    if (wr_ok && addr_i == A_MOD) mod_d = wdata_i;
  end

  // Buffered pair: act_q = 1 means channel 1 holds the active duty.
  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    live_d = live_q;
    if (!paired) begin
      act_d  = 1'b1;
      pend_d = 1'b1;
    end else begin
      if (wrap && pend_q) begin
        act_d  = ~act_q;
        live_d = act_q ? ch_val[0] : ch_val[1];
        pend_d = 1'b0;
      end
      if (wr_ok && ((addr_i == A_C0VAL && act_d) || (addr_i == A_C1VAL && !act_d)))
        pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      stop_q   <= 1'b1;
      ovf_ie_q <= 1'b0;
      mod_q    <= '1;
      act_q    <= 1'b1;
      pend_q   <= 1'b1;
      live_q   <= '0;
    end else begin
      stop_q   <= stop_d;
      ovf_ie_q <= ovf_ie_d;
      mod_q    <= mod_d;
      act_q    <= act_d;
      pend_q   <= pend_d;
      live_q   <= live_d;
    end
  end

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .run_i(!stop_q), .clr_i(cnt_clr),
    .mod_i(mod_q), .cnt_o(cnt), .wrap_o(wrap)
  );

  tmr_flag u_ovf_flag (
    .clk(clk), .rst_n(rst_s_n), .set_i(wrap),
    .rd_hit_i(rd_ok && addr_i == A_CTL), .wr_hit_i(ctl_wr),
    .wbit_i(wdata_i[0]), .flag_o(ovf_flag)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] CTL_A = AW'(3 + 2 * g);
    localparam logic [AW-1:0] VAL_A = AW'(4 + 2 * g);
    logic [W-1:0] cmp_src;
    logic         cmp_en;
    if (g == 0) begin : g_lead
      assign cmp_src = paired ? live_q : ch_val[g];
      assign cmp_en  = 1'b1;
    end else begin : g_follow
      assign cmp_src = ch_val[g];
      assign cmp_en  = !paired;
    end

    tmr_chan #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_s_n),
      .cfg_wr_i(wr_ok && addr_i == CTL_A), .val_wr_i(wr_ok && addr_i == VAL_A),
      .wdata_i(wdata_i), .cnt_i(cnt), .run_i(!stop_q), .wrap_i(wrap),
      .cmp_val_i(cmp_src), .cmp_en_i(cmp_en), .pin_i(ch_in_i[g]),
      .cfg_o(ch_cfg[g]), .val_o(ch_val[g]), .pin_o(ch_pin[g]), .evt_o(ch_evt[g])
    );

    tmr_flag u_flag (
      .clk(clk), .rst_n(rst_s_n), .set_i(ch_evt[g]),
      .rd_hit_i(rd_ok && addr_i == CTL_A), .wr_hit_i(wr_ok && addr_i == CTL_A),
      .wbit_i(wdata_i[0]), .flag_o(ch_flag[g])
    );

    assign ch_ie[g] = ch_cfg[g].ie;
  end

  assign ch_out_o[0] = ch_pin[0];
  assign ch_out_o[1] = ch_pin[1] & ~paired;
  assign irq_o = (ovf_flag & ovf_ie_q) | (|(ch_flag & ch_ie));

  always_comb begin
    rdata_o = '0;
    if (!lp_hold_i) begin
      case (addr_i)
        A_CTL:   rdata_o[3:0] = {1'b0, stop_q, ovf_ie_q, ovf_flag};
        A_MOD:   rdata_o = mod_q;
        A_CNT:   rdata_o = cnt;
        A_C0CTL: rdata_o[9:0] = {ch_cfg[0], ch_flag[0]};
        A_C0VAL: rdata_o = ch_val[0];
        A_C1CTL: rdata_o[9:0] = {ch_cfg[1], ch_flag[1]};
        A_C1VAL: rdata_o = ch_val[1];
        default: rdata_o = '0;
      endcase
    end
  end

  // R6
  swap_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (paired && !wrap) |=> $stable(act_q));
  // R10
  hold_mod_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    lp_hold_i |=> $stable(mod_q));
endmodule

// File: tb/tmr2ch_pwm_tb.sv
`timescale 1ns/1ps
module tmr2ch_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_hold = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] rdata;
  logic [1:0]  ch_in = '0;
  logic [1:0]  ch_out;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tmr2ch_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .lp_hold_i(lp_hold), .addr_i(addr),
    .wdata_i(wdata), .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
    .ch_in_i(ch_in), .ch_out_o(ch_out), .irq_o(irq)
  );

  // PWM vectors: modulo, compare, toggle, max, high cycles per period
  localparam int NV = 5;
  localparam int V_MOD [NV] = '{9, 9, 7, 9, 9};
  localparam int V_CMP [NV] = '{4, 0, 6, 4, 4};
  localparam int V_TOV [NV] = '{1, 1, 1, 0, 1};
  localparam int V_MAX [NV] = '{0, 0, 0, 0, 1};
  localparam int V_HI  [NV] = '{5, 1, 7, 0, 10};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic count_hi(input int idx, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (ch_out[idx]) hi++;
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq at reset", int'(irq), 0);
    chk("R1 pins at reset", int'(ch_out), 0);
    rd(4'd1, d); chk("R1 modulo reset", int'(d), 16'hFFFF);
    rd(4'd2, d); chk("R1 counter reset", int'(d), 0);
    rd(4'd0, d); chk("R1 R2 control reset", int'(d), 4);

    // R3 R4 duty table
    for (int i = 0; i < NV; i++) begin
      wr(4'd0, 16'h0005);
      wr(4'd1, 16'(V_MOD[i]));
      wr(4'd4, 16'(V_CMP[i]));
      wr(4'd3, 16'(1 | 8 | (V_TOV[i] << 6) | (V_MAX[i] << 7)));
      wr(4'd0, 16'h0009);
      repeat (2 * (V_MOD[i] + 1) + 3) @(negedge clk);
      count_hi(0, 3 * (V_MOD[i] + 1), hi);
      chk($sformatf("R3 R4 duty vector %0d", i), hi, 3 * V_HI[i]);
    end

    // R5 R6 buffered pair
    wr(4'd0, 16'h0005);
    wr(4'd1, 16'd9);
    wr(4'd4, 16'd3);
    wr(4'd6, 16'd0);
    wr(4'd3, 16'h0249);
    wr(4'd0, 16'h0009);
    repeat (25) @(negedge clk);
    count_hi(0, 30, hi); chk("R5 first duty from channel 0", hi, 12);
    count_hi(1, 30, hi); chk("R5 channel 1 pin low when paired", hi, 0);
    wr(4'd4, 16'd8);
    repeat (25) @(negedge clk);
    count_hi(0, 30, hi); chk("R6 active write has no effect", hi, 12);
    wr(4'd6, 16'd6);
    repeat (25) @(negedge clk);
    count_hi(0, 30, hi); chk("R6 idle channel 1 write goes live", hi, 21);
    wr(4'd4, 16'd1);
    repeat (25) @(negedge clk);
    count_hi(0, 30, hi); chk("R6 roles swapped, channel 0 idle", hi, 6);
    wr(4'd3, 16'h0001);

    // R7 R8 wrap flag and clear protocol
    wr(4'd0, 16'h0005);
    wr(4'd1, 16'd9);
    wr(4'd0, 16'h000B);
    repeat (12) @(negedge clk);
    chk("R7 irq with wrap flag enabled", int'(irq), 1);
    rd(4'd0, d); chk("R7 wrap flag set", int'(d[0]), 1);
    repeat (6) @(negedge clk);
    wr(4'd0, 16'h0002);
    rd(4'd0, d); chk("R8 event beats clear", int'(d[0]), 1);
    wr(4'd0, 16'h0007);
    wr(4'd0, 16'h0006);
    rd(4'd0, d); chk("R8 clear without read ignored", int'(d[0]), 1);
    wr(4'd0, 16'h0006);
    rd(4'd0, d); chk("R8 read then write 0 clears", int'(d[0]), 0);
    chk("R7 irq drops after clear", int'(irq), 0);

    // R2 R9 capture
    wr(4'd0, 16'h000D);
    wr(4'd1, 16'hFFFF);
    wr(4'd5, 16'h0015);
    wr(4'd0, 16'h0001);
    repeat (37) @(negedge clk);
    wr(4'd0, 16'h0005);
    rd(4'd2, d); chk("R2 stopped counter value", int'(d), 38);
    ch_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'd6, d); chk("R9 rising capture value", int'(d), 38);
    rd(4'd5, d); chk("R9 rising capture flag", int'(d[0]), 1);
    wr(4'd5, 16'h0014);
    ch_in[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(4'd5, d); chk("R9 falling ignored on rising select", int'(d[0]), 0);
    wr(4'd5, 16'h0025);
    ch_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'd5, d); chk("R9 rising ignored on falling select", int'(d[0]), 0);
    wr(4'd0, 16'h0001);
    repeat (9) @(negedge clk);
    wr(4'd0, 16'h0005);
    ch_in[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(4'd6, d); chk("R9 falling capture value", int'(d), 48);
    rd(4'd5, d); chk("R9 falling capture flag", int'(d[0]), 1);
    wr(4'd5, 16'h0034);
    wr(4'd5, 16'h0035);
    ch_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'd5, d); chk("R9 both-edge capture flag", int'(d[0]), 1);
    wr(4'd5, 16'h0001);

    // R10 low-power hold
    wr(4'd0, 16'h0005);
    wr(4'd1, 16'd9);
    wr(4'd0, 16'h000B);
    lp_hold = 1'b1;
    wr(4'd1, 16'd3);
    rd(4'd1, d); chk("R10 read during hold is 0", int'(d), 0);
    repeat (15) @(negedge clk);
    chk("R10 irq raised during hold", int'(irq), 1);
    lp_hold = 1'b0;
    rd(4'd1, d); chk("R10 write during hold ignored", int'(d), 9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule